// File: doc/BRIEF.md
# Mode-Filtered Cycle and Retire Counters

This block holds two 64-bit machine counters, one advanced by elapsed cycles and one by retired instructions. Each counter has a companion filter register with five inhibit flags, one per execution mode: machine, supervisor, user, guest supervisor and guest user. When a counter receives an increment event, the block works out which mode the hart was in for that step and tests that mode's flag. The counter advances only when the flag is clear.

Software reaches the counters and filter registers through a simple CSR port. Address, write data and write enable are sampled on the clock edge, and read data is combinational. Each clock cycle is one step. A filter write takes effect only after the next increment event of its counter, so the instruction that changes the filter, and any step before that counter's next event, is still judged by the old setting. When the mode changes during a step, the mode before the change is used. With `XLEN` set to 32, each 64-bit register is reached as a low and a high half.

Top module: `priv_filt_counters`

## Requirements
- R1: After reset both counters and both filter registers read zero.
- R2: Privilege is encoded U=0, S=1, M=3. Inhibit flags sit at bit 62 (machine), 61 (supervisor), 60 (user), 59 (guest supervisor) and 58 (guest user). U tests bit 58 when virtualized and bit 60 otherwise. S tests bit 59 when virtualized and bit 61 otherwise. Any other privilege value tests bit 62. On an increment event whose tested flag is 0, the counter grows by the event's amount. When the flag is 1, the counter is unchanged.
- R3: In machine mode, and for the unused privilege value 2, the virtualization input has no effect on which flag is tested.
- R4: When `mode_chg` is high, the previous privilege and virtualization inputs select the flag. Otherwise the current inputs select it.
- R5: A filter write captures the old filter value. Increment events in the same cycle as the write use the old value. So does the first increment event of that counter in a later cycle. Events after that use the new value.
- R6: A software write to a counter wins over an increment event in the same cycle. The written value is stored as is.
- R7: Only bits 62..58 of a filter register are writable. All other bits read 0.
- R8: With `FILTER_EN` = 0, filter registers ignore writes and read 0, and increments are never inhibited.
- R9: With `XLEN` = 32, the high halves are at 0xB80 (cycles), 0xB82 (retired) and 0x721/0x722 (filters). A half write changes only its own 32 bits. Increments carry from the low half into the high half.
- R10: An increment event with amount 0 leaves the counter unchanged but still discards a captured filter value.
- R11: Cycles are at 0xB00, retired instructions at 0xB02, and the filters at 0x321 (cycles) and 0x322 (retired). Any other address reads 0. With `XLEN` = 64, a read returns all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| priv_cur | input | 2 | Privilege level at the end of the step |
| virt_cur | input | 1 | Virtualization flag at the end of the step |
| priv_prev | input | 2 | Privilege level before a change in this step |
| virt_prev | input | 1 | Virtualization flag before a change in this step |
| mode_chg | input | 1 | A mode change took place during this step |
| cyc_bump | input | 1 | Increment event for the cycle counter |
| cyc_amt | input | AMT_W | Increment amount for the cycle counter |
| ret_bump | input | 1 | Increment event for the retired-instruction counter |
| ret_amt | input | AMT_W | Increment amount for the retired-instruction counter |

## Verification
Capture state is the riskiest internal state. If the captured filter value is held too long or dropped too early, a counter diverges on the first increment event after a filter write. That shows up as an off-by-amount count one step after the event. A wrong mode choice shows up on the next increment in the affected mode, as a count that moved when it should have held, or the reverse. The bench reads every mapped register after each cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;
   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   localparam int CNT_W = 64;
   localparam int HALF_W = CNT_W / 2;
   localparam int POS_W = $clog2(CNT_W);

   localparam logic [POS_W-1:0] INH_M  = POS_W'(62);
   localparam logic [POS_W-1:0] INH_S  = POS_W'(61);
   localparam logic [POS_W-1:0] INH_U  = POS_W'(60);
   localparam logic [POS_W-1:0] INH_VS = POS_W'(59);
   localparam logic [POS_W-1:0] INH_VU = POS_W'(58);

   localparam logic [CNT_W-1:0] INH_MASK =
      (CNT_W'(1) << INH_M) | (CNT_W'(1) << INH_S) | (CNT_W'(1) << INH_U) |
      (CNT_W'(1) << INH_VS) | (CNT_W'(1) << INH_VU);

   localparam logic [11:0] A_CYC_LO = 12'hB00;
   localparam logic [11:0] A_RET_LO = 12'hB02;
   localparam logic [11:0] A_CYC_HI = 12'hB80;
   localparam logic [11:0] A_RET_HI = 12'hB82;
   localparam logic [11:0] A_FCY_LO = 12'h321;
   localparam logic [11:0] A_FRT_LO = 12'h322;
   localparam logic [11:0] A_FCY_HI = 12'h721;
   localparam logic [11:0] A_FRT_HI = 12'h722;
endpackage

// File: rtl/pfc_mode_sel.sv
`timescale 1ns/1ps
module pfc_mode_sel
   import pfc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       priv_cur,
   input  logic             virt_cur,
   input  logic [1:0]       priv_prev,
   input  logic             virt_prev,
   input  logic             mode_chg,
   output logic [POS_W-1:0] inh_pos
);
   priv_e fpriv;
   logic  fvirt;

   always_comb begin
      fpriv = priv_e'(mode_chg ? priv_prev : priv_cur);
      fvirt = mode_chg ? virt_prev : virt_cur;
      unique case (fpriv)
         PRIV_U:  inh_pos = fvirt ? INH_VU : INH_U;
         PRIV_S:  inh_pos = fvirt ? INH_VS : INH_S;
         default: inh_pos = INH_M;
      endcase
   end

   assert_mach_novirt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && priv_cur == 2'd3) |-> inh_pos == INH_M);

   assert_prev_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && priv_prev == 2'd1 && virt_prev) |-> inh_pos == INH_VS);
endmodule

// File: rtl/pfc_cfg.sv
`timescale 1ns/1ps
module pfc_cfg
   import pfc_pkg::*;
#(
   parameter bit FILTER_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [CNT_W-1:0] wdata,
   input  logic             bump,
   input  logic [POS_W-1:0] inh_pos,
   output logic [CNT_W-1:0] cfg_q,
   output logic             cnt_en
);
   generate
      if (FILTER_EN) begin : g_filt
         logic [CNT_W-1:0] cap_q;
         logic             cap_v;
         logic [CNT_W-1:0] eff;
         logic             wr;

         assign wr = wr_lo | wr_hi;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cfg_q <= '0;
               cap_q <= '0;
               cap_v <= 1'b0;
            end else begin
               if (wr) cap_q <= cfg_q;
               if (wr_lo) cfg_q[HALF_W-1:0] <= wdata[HALF_W-1:0] & INH_MASK[HALF_W-1:0];
               if (wr_hi) cfg_q[CNT_W-1:HALF_W] <= wdata[CNT_W-1:HALF_W] & INH_MASK[CNT_W-1:HALF_W];
               if (bump)    cap_v <= 1'b0;
               else if (wr) cap_v <= 1'b1;
            end
         end

         always_comb begin
            if (wr)         eff = cfg_q;
            else if (cap_v) eff = cap_q;
            else            eff = cfg_q;
            cnt_en = ~eff[inh_pos];
         end

         assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q & ~INH_MASK) == '0);

         assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !bump) |=> (cap_v && cap_q == $past(cfg_q)));

         assert_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
            bump |=> !cap_v);
      end else begin : g_nofilt
         assign cfg_q  = '0;
         assign cnt_en = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pfc_counter.sv
`timescale 1ns/1ps
module pfc_counter
   import pfc_pkg::*;
#(
   parameter int AMT_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [CNT_W-1:0] wdata,
   input  logic             bump,
   input  logic             cnt_en,
   input  logic [AMT_W-1:0] amt,
   output logic [CNT_W-1:0] cnt_q
);
   logic [CNT_W-1:0] cnt_d;
   logic             wr;

   assign wr = wr_lo | wr_hi;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_lo) cnt_d[HALF_W-1:0] = wdata[HALF_W-1:0];
      if (wr_hi) cnt_d[CNT_W-1:HALF_W] = wdata[CNT_W-1:HALF_W];
      if (!wr && bump && cnt_en) cnt_d = cnt_q + CNT_W'(amt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && bump && cnt_en) |=> cnt_q == $past(cnt_q) + CNT_W'($past(amt)));

   assert_inhibit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !(bump && cnt_en)) |=> $stable(cnt_q));

   assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> cnt_q[HALF_W-1:0] == $past(wdata[HALF_W-1:0]));

   assert_half_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/priv_filt_counters.sv
`timescale 1ns/1ps
module priv_filt_counters
   import pfc_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit FILTER_EN = 1'b1,
   parameter int AMT_W     = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [11:0]      csr_addr,
   input  logic [XLEN-1:0]  csr_wdata,
   input  logic             csr_we,
   output logic [XLEN-1:0]  csr_rdata,
   input  logic [1:0]       priv_cur,
   input  logic             virt_cur,
   input  logic [1:0]       priv_prev,
   input  logic             virt_prev,
   input  logic             mode_chg,
   input  logic             cyc_bump,
   input  logic [AMT_W-1:0] cyc_amt,
   input  logic             ret_bump,
   input  logic [AMT_W-1:0] ret_amt
);
   localparam int N_CH = 2;
   localparam logic [11:0] CNT_LO_A [N_CH] = '{A_CYC_LO, A_RET_LO};
   localparam logic [11:0] CNT_HI_A [N_CH] = '{A_CYC_HI, A_RET_HI};
   localparam logic [11:0] CFG_LO_A [N_CH] = '{A_FCY_LO, A_FRT_LO};
   localparam logic [11:0] CFG_HI_A [N_CH] = '{A_FCY_HI, A_FRT_HI};

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("priv_filt_counters: XLEN must be 32 or 64");
      end
      if (AMT_W < 1 || AMT_W > 16) begin : g_bad_amt
         $error("priv_filt_counters: AMT_W must be 1..16");
      end
   endgenerate

   logic [CNT_W-1:0]       wd64;
   logic [POS_W-1:0]       inh_pos;
   logic [N_CH-1:0]        bump_v;
   logic [AMT_W-1:0]       amt_v   [N_CH];
   logic [N_CH-1:0]        cnt_wlo, cnt_whi, cfg_wlo, cfg_whi, en_v;
   logic [CNT_W-1:0]       cnt_q   [N_CH];
   logic [CNT_W-1:0]       cfg_q   [N_CH];

   assign bump_v   = {ret_bump, cyc_bump};
   assign amt_v[0] = cyc_amt;
   assign amt_v[1] = ret_amt;

   generate
      if (XLEN == 64) begin : g_x64
         assign wd64 = CNT_W'(csr_wdata);
      end else begin : g_x32
         assign wd64 = {csr_wdata, csr_wdata};
      end
   endgenerate

   pfc_mode_sel u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .priv_cur  (priv_cur),
      .virt_cur  (virt_cur),
      .priv_prev (priv_prev),
      .virt_prev (virt_prev),
      .mode_chg  (mode_chg),
      .inh_pos   (inh_pos)
   );

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
         assign cnt_wlo[i] = csr_we && (csr_addr == CNT_LO_A[i]);
         assign cfg_wlo[i] = csr_we && (csr_addr == CFG_LO_A[i]);
         if (XLEN == 64) begin : g_full
            assign cnt_whi[i] = cnt_wlo[i];
            assign cfg_whi[i] = cfg_wlo[i];
         end else begin : g_half
            assign cnt_whi[i] = csr_we && (csr_addr == CNT_HI_A[i]);
            assign cfg_whi[i] = csr_we && (csr_addr == CFG_HI_A[i]);
         end

         pfc_cfg #(.FILTER_EN(FILTER_EN)) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (cfg_wlo[i]),
            .wr_hi   (cfg_whi[i]),
            .wdata   (wd64),
            .bump    (bump_v[i]),
            .inh_pos (inh_pos),
            .cfg_q   (cfg_q[i]),
            .cnt_en  (en_v[i])
         );

         pfc_counter #(.AMT_W(AMT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (cnt_wlo[i]),
            .wr_hi  (cnt_whi[i]),
            .wdata  (wd64),
            .bump   (bump_v[i]),
            .cnt_en (en_v[i]),
            .amt    (amt_v[i]),
            .cnt_q  (cnt_q[i])
         );
      end
   endgenerate

   logic [CNT_W-1:0] rd_val;
   logic             rd_hi;

   always_comb begin
      rd_val = '0;
      rd_hi  = 1'b0;
      for (int i = 0; i < N_CH; i++) begin
         if (csr_addr == CNT_LO_A[i]) rd_val = cnt_q[i];
         if (csr_addr == CFG_LO_A[i]) rd_val = cfg_q[i];
         if (XLEN == 32) begin
            if (csr_addr == CNT_HI_A[i]) begin
               rd_val = cnt_q[i];
               rd_hi  = 1'b1;
            end
            if (csr_addr == CFG_HI_A[i]) begin
               rd_val = cfg_q[i];
               rd_hi  = 1'b1;
            end
         end
      end
   end

   assign csr_rdata = XLEN'(rd_hi ? CNT_W'(rd_val[CNT_W-1:HALF_W]) : rd_val);

   assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == A_FCY_LO) |-> (csr_rdata & ~XLEN'(INH_MASK)) == '0);
endmodule

// File: tb/sim_priv_filt_counters.sv
`timescale 1ns/1ps
module sim_priv_filt_counters;
   localparam logic [11:0] CYL = 12'hB00, RTL_ = 12'hB02, CYH = 12'hB80, RTH = 12'hB82;
   localparam logic [11:0] FCL = 12'h321, FRL = 12'h322, FCH = 12'h721, FRH = 12'h722;
   localparam logic [31:0] B_M = 32'h4000_0000, B_S = 32'h2000_0000, B_U = 32'h1000_0000;
   localparam logic [31:0] B_VS = 32'h0800_0000, B_VU = 32'h0400_0000;
   localparam logic [1:0] PU = 2'd0, PS = 2'd1, PR = 2'd2, PM = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int failures = 0;

   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_rdata;
   logic [1:0]  priv_cur = PM, priv_prev = PM;
   logic        virt_cur = 1'b0, virt_prev = 1'b0, mode_chg = 1'b0;
   logic        cyc_bump = 1'b0, ret_bump = 1'b0;
   logic [1:0]  cyc_amt = '0, ret_amt = '0;

   priv_filt_counters #(.XLEN(32), .FILTER_EN(1'b1), .AMT_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_we(csr_we), .csr_rdata(csr_rdata), .priv_cur(priv_cur),
      .virt_cur(virt_cur), .priv_prev(priv_prev), .virt_prev(virt_prev),
      .mode_chg(mode_chg), .cyc_bump(cyc_bump), .cyc_amt(cyc_amt),
      .ret_bump(ret_bump), .ret_amt(ret_amt)
   );

   logic [11:0] b_addr = '0;
   logic [63:0] b_wdata = '0;
   logic        b_we = 1'b0, b_bump = 1'b0;
   logic [63:0] b_rdata;

   priv_filt_counters #(.XLEN(64), .FILTER_EN(1'b0), .AMT_W(2)) u1 (
      .clk(clk), .rst_n(rst_n), .csr_addr(b_addr), .csr_wdata(b_wdata),
      .csr_we(b_we), .csr_rdata(b_rdata), .priv_cur(PM), .virt_cur(1'b0),
      .priv_prev(PM), .virt_prev(1'b0), .mode_chg(1'b0), .cyc_bump(b_bump),
      .cyc_amt(2'd1), .ret_bump(1'b0), .ret_amt(2'd0)
   );

   logic [63:0] m_cnt [2];
   logic [63:0] m_cfg [2];
   logic [63:0] m_cap [2];
   bit          m_capv [2];

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [11:0] a);
      case (a)
         CYL: return m_cnt[0][31:0];
         CYH: return m_cnt[0][63:32];
         RTL_: return m_cnt[1][31:0];
         RTH: return m_cnt[1][63:32];
         FCL: return m_cfg[0][31:0];
         FCH: return m_cfg[0][63:32];
         FRL: return m_cfg[1][31:0];
         FRH: return m_cfg[1][63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare_all(input string req);
      logic [11:0] addrs [9] = '{CYL, CYH, RTL_, RTH, FCL, FCH, FRL, FRH, 12'h123};
      for (int k = 0; k < 9; k++) begin
         csr_addr = addrs[k];
         #0.15;
         chk(64'(csr_rdata), 64'(exp_rd(addrs[k])), (k == 8) ? "R11" : req,
             $sformatf("addr %h", addrs[k]));
      end
   endtask

   task automatic step(input logic [11:0] a, input logic [31:0] wd, input logic we,
                       input logic [1:0] pc, input logic vc, input logic [1:0] pp,
                       input logic vp, input logic mc, input logic cb, input logic [1:0] ca,
                       input logic rb, input logic [1:0] ra, input string req);
      logic [1:0] fp;
      logic       fv;
      int         bitpos;
      bit         bmp [2];
      logic [1:0] am [2];
      @(negedge clk);
      csr_addr = a; csr_wdata = wd; csr_we = we;
      priv_cur = pc; virt_cur = vc; priv_prev = pp; virt_prev = vp; mode_chg = mc;
      cyc_bump = cb; cyc_amt = ca; ret_bump = rb; ret_amt = ra;
      fp = mc ? pp : pc;
      fv = mc ? vp : vc;
      if (fp == PU)      bitpos = fv ? 58 : 60;
      else if (fp == PS) bitpos = fv ? 59 : 61;
      else               bitpos = 62;
      bmp[0] = cb; bmp[1] = rb; am[0] = ca; am[1] = ra;
      for (int i = 0; i < 2; i++) begin
         logic [11:0] cl = (i == 0) ? CYL : RTL_;
         logic [11:0] ch = (i == 0) ? CYH : RTH;
         logic [11:0] fl = (i == 0) ? FCL : FRL;
         logic [11:0] fh = (i == 0) ? FCH : FRH;
         bit cwr = we && (a == cl || a == ch);
         bit fwr = we && (a == fl || a == fh);
         logic [63:0] eff = fwr ? m_cfg[i] : (m_capv[i] ? m_cap[i] : m_cfg[i]);
         if (cwr) begin
            if (a == cl) m_cnt[i][31:0] = wd;
            else         m_cnt[i][63:32] = wd;
         end else if (bmp[i] && !eff[bitpos]) begin
            m_cnt[i] = m_cnt[i] + 64'(am[i]);
         end
         if (fwr) begin
            m_cap[i] = m_cfg[i];
            if (a == fl) m_cfg[i][31:0] = 32'h0;
            else         m_cfg[i][63:32] = wd & 32'h7C00_0000;
         end
         if (bmp[i])   m_capv[i] = 1'b0;
         else if (fwr) m_capv[i] = 1'b1;
      end
      @(posedge clk);
      #0.1;
      csr_we = 1'b0; cyc_bump = 1'b0; ret_bump = 1'b0;
      compare_all(req);
   endtask

   task automatic bumpm(input logic cb, input logic [1:0] ca, input logic rb, input logic [1:0] ra, input string req);
      step(12'h0, 32'h0, 1'b0, PM, 1'b0, PM, 1'b0, 1'b0, cb, ca, rb, ra, req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic cb, input logic rb, input string req);
      step(a, d, 1'b1, PM, 1'b0, PM, 1'b0, 1'b0, cb, 2'd1, rb, 2'd1, req);
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_cnt[i] = '0; m_cfg[i] = '0; m_cap[i] = '0; m_capv[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.1;
      compare_all("R1");

      // R2 plain counting in machine mode, amounts 1 and 2
      for (int n = 0; n < 3; n++) bumpm(1'b1, 2'd1, 1'b1, 2'd2, "R2");

      // R5 filter write with bump in the same cycle uses old value
      wr(FCH, B_M, 1'b1, 1'b0, "R5");
      bumpm(1'b1, 2'd1, 1'b0, 2'd0, "R2");
      // R5 capture survives idle cycles until the next event
      wr(FRH, B_M, 1'b0, 1'b0, "R5");
      bumpm(1'b0, 2'd0, 1'b0, 2'd0, "R5");
      bumpm(1'b0, 2'd0, 1'b0, 2'd0, "R5");
      bumpm(1'b0, 2'd0, 1'b1, 2'd1, "R5");
      bumpm(1'b0, 2'd0, 1'b1, 2'd1, "R2");

      // R2 supervisor and guest modes
      step(12'h0, 0, 1'b0, PS, 1'b0, PS, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 2'd1, "R2");
      step(FCH, B_S | B_M, 1'b1, PS, 1'b0, PS, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R5");
      step(12'h0, 0, 1'b0, PS, 1'b0, PS, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R2");
      step(12'h0, 0, 1'b0, PS, 1'b1, PS, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R2");
      step(FCH, B_VS, 1'b1, PS, 1'b1, PS, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, "R5");
      step(12'h0, 0, 1'b0, PS, 1'b1, PS, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R5");
      step(12'h0, 0, 1'b0, PS, 1'b1, PS, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R2");
      step(12'h0, 0, 1'b0, PU, 1'b0, PU, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd1, "R2");

      // R10 zero-amount event discards capture
      wr(FCH, B_VU | B_VS, 1'b0, 1'b0, "R5");
      bumpm(1'b1, 2'd0, 1'b0, 2'd0, "R10");
      step(12'h0, 0, 1'b0, PU, 1'b1, PU, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R10");

      // R3 machine and reserved level ignore virtualization
      step(12'h0, 0, 1'b0, PM, 1'b1, PM, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R3");
      step(12'h0, 0, 1'b0, PR, 1'b1, PR, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R3");

      // R4 mode change uses previous mode
      step(12'h0, 0, 1'b0, PU, 1'b1, PM, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 2'd0, "R4");
      step(12'h0, 0, 1'b0, PM, 1'b0, PS, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 2'd0, "R4");
      step(12'h0, 0, 1'b0, PM, 1'b0, PS, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, "R4");

      // R6 counter write beats bump; R9 half writes
      wr(CYL, 32'h0000_1234, 1'b1, 1'b1, "R6");
      wr(RTH, 32'h0000_0005, 1'b1, 1'b1, "R9");
      wr(CYL, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9");
      bumpm(1'b1, 2'd1, 1'b0, 2'd0, "R9");
      bumpm(1'b1, 2'd3, 1'b0, 2'd0, "R9");

      // R7 only inhibit bits are writable
      wr(FCL, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
      wr(FRH, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
      bumpm(1'b1, 2'd0, 1'b1, 2'd0, "R10");
      bumpm(1'b1, 2'd1, 1'b1, 2'd1, "R7");

      // R8 filtering disabled instance (XLEN 64)
      @(negedge clk);
      b_addr = 12'h321; b_wdata = '1; b_we = 1'b1; b_bump = 1'b1;
      @(negedge clk);
      b_we = 1'b0; b_bump = 1'b1;
      @(negedge clk);
      b_bump = 1'b0;
      b_addr = 12'h321; #0.2; chk(b_rdata, 64'h0, "R8", "filter reads zero");
      b_addr = 12'hB00; #0.2; chk(b_rdata, 64'd2, "R8", "never inhibited");
      b_addr = 12'hB80; #0.2; chk(b_rdata, 64'h0, "R11", "no high half at 64");
      @(negedge clk);
      b_addr = 12'hB02; b_wdata = 64'h1234_5678_9ABC_DEF0; b_we = 1'b1;
      @(negedge clk);
      b_we = 1'b0;
      #0.2; chk(b_rdata, 64'h1234_5678_9ABC_DEF0, "R11", "full 64-bit read");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule